// File: doc/BRIEF.md
# Differential Lane Centring Sequencer

This block calibrates one differential receive input whose two halves arrive as separate 8-bit words. Both halves are sampled at half the bit rate, so each unit interval is seen once on the N lane and once on the P lane. Each lane has its own tap delay line outside the block, with a load port and an increment/decrement port. From reset a sequencer first steps both delays until both lanes read a clean training pattern. It then finds both edges of the N lane's clean window and parks N midway between them. Next it walks P downward through the noisy transition zone and parks P in the middle of that zone. From then on P samples the data edges while N samples the data centres.

Once P is parked the block declares lock. It forwards the N word as received data with a valid flag and switches to tracking. Tracking is an early/late phase decision over each data/edge word pair. After every decision the block waits a settling time, and each decision moves both delays one tap in the same direction. This follows slow drift in voltage and temperature without disturbing the centre/edge spacing between the lanes.

Top module: `diff_lane_aligner`

## Requirements
- R1: An asynchronous active-high `rst` clears `rx_valid` and `rx_data` at once and restarts the sequence. The first command after reset loads both delays with `START_TAP` (default 2^(TAP_W-1)).
- R2: A tap position is clean when the lane's words all equal `TRAIN_PAT` over `WIN` consecutive words, counted after a wait of `SETTLE` cycles following the move. Otherwise the position is noisy.
- R3: While either lane is noisy at the start position, both delays step up together one tap per evaluation. The search ends when both lanes are clean or either lane reaches the top tap.
- R4: The N delay then steps down one tap per evaluation. The left edge is the lowest clean tap above the first noisy one, or tap 0 if tap 0 is clean.
- R5: N is reloaded to the left edge and steps up. The right edge is the last clean tap, or the top tap. N is then loaded with (left + right) >> 1.
- R6: P steps down from its clean position. The first noisy tap is the upper bound of the noise zone. The lowest noisy tap in the run below it is the lower bound, or 0 if the run reaches tap 0. P is then loaded with (lower + upper) >> 1.
- R7: `rx_valid` rises one cycle after the load that parks P and stays high until reset. No load command is issued while `rx_valid` is high.
- R8: While `rx_valid` is high, `rx_data` equals the `n_word` sampled on the previous clock edge. Otherwise `rx_data` is 0.
- R9: Tracking uses bit pairs i = 0..6, where bit 0 is the earliest. `p_word[i]` is the edge sample between `n_word[i]` and `n_word[i+1]`. Where those two data bits differ, an edge sample equal to bit i votes early and one equal to bit i+1 votes late. With more early votes both delays step up one tap; with more late votes both step down; a tie moves nothing. One decision is taken per `SETTLE+1` cycles.
- R10: `ld` and `ce` are never high together on a lane. A step never leaves the range 0 to 2^TAP_W-1. While tracking, the two lanes' `ce` and `inc` are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Asynchronous reset, active high |
| n_word | input | 8 | Deserialized N lane word, bit 0 earliest |
| p_word | input | 8 | Deserialized P lane word, bit 0 earliest |
| n_ld | output | 1 | Load `n_val` into the N delay |
| n_ce | output | 1 | Step the N delay by one tap |
| n_inc | output | 1 | Step direction for N, 1 = up |
| n_val | output | TAP_W | Load value for the N delay |
| p_ld | output | 1 | Load `p_val` into the P delay |
| p_ce | output | 1 | Step the P delay by one tap |
| p_inc | output | 1 | Step direction for P, 1 = up |
| p_val | output | TAP_W | Load value for the P delay |
| rx_data | output | 8 | Forwarded N lane data |
| rx_valid | output | 1 | Lock flag, data valid |

## Verification
The bench builds the block with TAP_W = 5, SETTLE = 4 and WIN = 8. A 32-tap delay line makes both ends of the range reachable in a few hundred cycles, and the short window keeps each evaluation near 14 cycles. This lets one run cover three eye layouts: one centred on the start tap, one where the start tap is noisy and the joint upward search is needed, and one where the clean window fills the whole range so that both searches end on a limit. Tracking is then driven by moving the modelled edge position up and down, and both delays are expected to follow with their spacing unchanged.

// File: rtl/dla_pkg.sv
package dla_pkg;

   localparam int LANES = 2;
   localparam int LN    = 0;
   localparam int LP    = 1;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_START,
      ST_VALID,
      ST_NLEFT,
      ST_NRIGHT,
      ST_NCTR,
      ST_PSEEK,
      ST_PNOISE,
      ST_PEDGE,
      ST_TRACK
   } seq_state_e;

   typedef struct packed {
      logic load;
      logic step;
      logic up;
   } tap_cmd_t;

endpackage

// File: rtl/dla_tap_ctrl.sv
module dla_tap_ctrl
   import dla_pkg::*;
#(
   parameter int TAP_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  tap_cmd_t         cmd,
   input  logic [TAP_W-1:0] load_val,
   output logic [TAP_W-1:0] tap,
   output logic             ld,
   output logic             ce,
   output logic             inc,
   output logic [TAP_W-1:0] val
);
   localparam logic [TAP_W-1:0] TMAX = '1;

   logic can_step;

   // saturate at both ends of the delay line
   always_comb begin
      can_step = cmd.step && !cmd.load &&
                 (cmd.up ? (tap != TMAX) : (tap != '0));
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         tap <= '0;
         ld  <= 1'b0;
         ce  <= 1'b0;
         inc <= 1'b0;
         val <= '0;
      end else begin
         ld  <= cmd.load;
         ce  <= can_step;
         inc <= cmd.up;
         val <= load_val;
         if (cmd.load)
            tap <= load_val;
         else if (can_step)
            tap <= cmd.up ? tap + 1'b1 : tap - 1'b1;
      end
   end
endmodule

// File: rtl/dla_lane_eval.sv
module dla_lane_eval #(
   parameter int               WORD_W    = 8,
   parameter logic [WORD_W-1:0] TRAIN_PAT = 8'h5A,
   parameter int               SETTLE    = 8,
   parameter int               WIN       = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   output logic              done,
   output logic              noisy
);
   localparam int LAST = SETTLE + WIN - 1;
   localparam int CW   = $clog2(LAST + 1);

   logic [CW-1:0] cnt;
   logic          busy;
   logic          bad;
   logic          err;

   always_comb begin
      err = (word != TRAIN_PAT) && (cnt >= CW'(SETTLE));
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt   <= '0;
         busy  <= 1'b0;
         bad   <= 1'b0;
         done  <= 1'b0;
         noisy <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            cnt  <= '0;
            busy <= 1'b1;
            bad  <= 1'b0;
         end else if (busy) begin
            if (cnt == CW'(LAST)) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               noisy <= bad | err;
            end else begin
               cnt <= cnt + 1'b1;
               bad <= bad | err;
            end
         end
      end
   end
endmodule

// File: rtl/dla_bb_vote.sv
module dla_bb_vote #(
   parameter int WORD_W = 8
) (
   input  logic [WORD_W-1:0] d,
   input  logic [WORD_W-2:0] e,
   output logic              early,
   output logic              late
);
   int n_early;
   int n_late;

   always_comb begin
      n_early = 0;
      n_late  = 0;
      for (int i = 0; i < WORD_W - 1; i++) begin
         if (d[i] != d[i+1]) begin
            if (e[i] == d[i])
               n_early = n_early + 1;
            else
               n_late = n_late + 1;
         end
      end
      early = n_early > n_late;
      late  = n_late > n_early;
   end
endmodule

// File: rtl/diff_lane_aligner.sv
module diff_lane_aligner
   import dla_pkg::*;
#(
   parameter int                TAP_W     = 5,
   parameter int                START_TAP = 2 ** (TAP_W - 1),
   parameter int                SETTLE    = 8,
   parameter int                WIN       = 64,
   parameter int                WORD_W    = 8,
   parameter logic [WORD_W-1:0] TRAIN_PAT = 8'h5A
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] n_word,
   input  logic [WORD_W-1:0] p_word,
   output logic              n_ld,
   output logic              n_ce,
   output logic              n_inc,
   output logic [TAP_W-1:0]  n_val,
   output logic              p_ld,
   output logic              p_ce,
   output logic              p_inc,
   output logic [TAP_W-1:0]  p_val,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid
);
   localparam logic [TAP_W-1:0] TMAX   = '1;
   localparam logic [TAP_W-1:0] TSTART = TAP_W'(START_TAP);
   localparam int               TCW    = $clog2(SETTLE + 1);

   generate
      if (SETTLE < 2) begin : g_bad_settle
         $error("SETTLE must cover the two-cycle delay command path");
      end
      if (WIN < 1) begin : g_bad_win
         $error("WIN must be at least one word");
      end
      if (START_TAP < 0 || START_TAP >= 2 ** TAP_W) begin : g_bad_start
         $error("START_TAP outside the delay range");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must hold at least one bit pair");
      end
   endgenerate

   seq_state_e       state, nxt;
   tap_cmd_t         cmd     [LANES];
   logic [TAP_W-1:0] lval    [LANES];
   logic [TAP_W-1:0] tap     [LANES];
   logic [TAP_W-1:0] val_o   [LANES];
   logic             ld_o    [LANES];
   logic             ce_o    [LANES];
   logic             inc_o   [LANES];
   logic [WORD_W-1:0] word   [LANES];
   logic             ev_done [LANES];
   logic             ev_noisy[LANES];
   logic             ev_start;

   logic [TAP_W-1:0] left_q, right_q, lo_q, hi_q;
   logic [TAP_W-1:0] left_d, right_d, lo_d, hi_d;
   logic             lock_q, lock_d;
   logic [TCW-1:0]   trk_cnt;
   logic             early, late;
   logic [TAP_W:0]   n_sum, p_sum;
   logic             done, nz_n, nz_p;

   assign word[LN] = n_word;
   assign word[LP] = p_word;

   // one delay controller and one window evaluator per lane
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dla_tap_ctrl #(.TAP_W(TAP_W)) u_tap (
         .clk      (clk),
         .rst      (rst),
         .cmd      (cmd[g]),
         .load_val (lval[g]),
         .tap      (tap[g]),
         .ld       (ld_o[g]),
         .ce       (ce_o[g]),
         .inc      (inc_o[g]),
         .val      (val_o[g])
      );
      dla_lane_eval #(
         .WORD_W    (WORD_W),
         .TRAIN_PAT (TRAIN_PAT),
         .SETTLE    (SETTLE),
         .WIN       (WIN)
      ) u_eval (
         .clk   (clk),
         .rst   (rst),
         .start (ev_start),
         .word  (word[g]),
         .done  (ev_done[g]),
         .noisy (ev_noisy[g])
      );
   end

   dla_bb_vote #(.WORD_W(WORD_W)) u_vote (
      .d     (n_word),
      .e     (p_word[WORD_W-2:0]),
      .early (early),
      .late  (late)
   );

   assign n_ld  = ld_o[LN];
   assign n_ce  = ce_o[LN];
   assign n_inc = inc_o[LN];
   assign n_val = val_o[LN];
   assign p_ld  = ld_o[LP];
   assign p_ce  = ce_o[LP];
   assign p_inc = inc_o[LP];
   assign p_val = val_o[LP];

   always_comb begin
      n_sum = {1'b0, left_q} + {1'b0, right_q};
      p_sum = {1'b0, lo_q} + {1'b0, hi_q};
      done  = ev_done[LN] & ev_done[LP];
      nz_n  = ev_noisy[LN];
      nz_p  = ev_noisy[LP];
   end

   always_comb begin
      nxt      = state;
      ev_start = 1'b0;
      left_d   = left_q;
      right_d  = right_q;
      lo_d     = lo_q;
      hi_d     = hi_q;
      lock_d   = lock_q;
      for (int i = 0; i < LANES; i++) begin
         cmd[i]  = '0;
         lval[i] = '0;
      end
      unique case (state)
         ST_IDLE: nxt = ST_START;
         ST_START: begin
            cmd[LN].load = 1'b1;  lval[LN] = TSTART;
            cmd[LP].load = 1'b1;  lval[LP] = TSTART;
            ev_start     = 1'b1;
            nxt          = ST_VALID;
         end
         ST_VALID: if (done) begin
            if ((!nz_n && !nz_p) || tap[LN] == TMAX || tap[LP] == TMAX) begin
               if (tap[LN] == '0) begin
                  left_d       = '0;
                  cmd[LN].load = 1'b1;
                  lval[LN]     = '0;
                  nxt          = ST_NRIGHT;
               end else begin
                  cmd[LN].step = 1'b1;
                  nxt          = ST_NLEFT;
               end
            end else begin
               cmd[LN].step = 1'b1;  cmd[LN].up = 1'b1;
               cmd[LP].step = 1'b1;  cmd[LP].up = 1'b1;
            end
            ev_start = 1'b1;
         end
         ST_NLEFT: if (done) begin
            if (nz_n || tap[LN] == '0) begin
               left_d       = nz_n ? tap[LN] + 1'b1 : '0;
               cmd[LN].load = 1'b1;
               lval[LN]     = left_d;
               nxt          = ST_NRIGHT;
            end else begin
               cmd[LN].step = 1'b1;
            end
            ev_start = 1'b1;
         end
         ST_NRIGHT: if (done) begin
            if (nz_n || tap[LN] == TMAX) begin
               right_d = (nz_n && tap[LN] != left_q) ? tap[LN] - 1'b1 :
                         (nz_n ? left_q : TMAX);
               nxt     = ST_NCTR;
            end else begin
               cmd[LN].step = 1'b1;  cmd[LN].up = 1'b1;
               ev_start     = 1'b1;
            end
         end
         ST_NCTR: begin
            cmd[LN].load = 1'b1;
            lval[LN]     = n_sum[TAP_W:1];
            if (tap[LP] == '0) begin
               lo_d = '0;
               hi_d = '0;
               nxt  = ST_PEDGE;
            end else begin
               cmd[LP].step = 1'b1;
               ev_start     = 1'b1;
               nxt          = ST_PSEEK;
            end
         end
         ST_PSEEK: if (done) begin
            if (nz_p && tap[LP] != '0) begin
               hi_d         = tap[LP];
               cmd[LP].step = 1'b1;
               ev_start     = 1'b1;
               nxt          = ST_PNOISE;
            end else if (tap[LP] == '0) begin
               hi_d = '0;
               lo_d = '0;
               nxt  = ST_PEDGE;
            end else begin
               cmd[LP].step = 1'b1;
               ev_start     = 1'b1;
            end
         end
         ST_PNOISE: if (done) begin
            if (!nz_p) begin
               lo_d = tap[LP] + 1'b1;
               nxt  = ST_PEDGE;
            end else if (tap[LP] == '0) begin
               lo_d = '0;
               nxt  = ST_PEDGE;
            end else begin
               cmd[LP].step = 1'b1;
               ev_start     = 1'b1;
            end
         end
         ST_PEDGE: begin
            cmd[LP].load = 1'b1;
            lval[LP]     = p_sum[TAP_W:1];
            lock_d       = 1'b1;
            nxt          = ST_TRACK;
         end
         ST_TRACK: if (trk_cnt == TCW'(SETTLE)) begin
            if (early && tap[LN] != TMAX && tap[LP] != TMAX) begin
               cmd[LN].step = 1'b1;  cmd[LN].up = 1'b1;
               cmd[LP].step = 1'b1;  cmd[LP].up = 1'b1;
            end else if (late && tap[LN] != '0 && tap[LP] != '0) begin
               cmd[LN].step = 1'b1;
               cmd[LP].step = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state    <= ST_IDLE;
         left_q   <= '0;
         right_q  <= '0;
         lo_q     <= '0;
         hi_q     <= '0;
         lock_q   <= 1'b0;
         trk_cnt  <= '0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
      end else begin
         state    <= nxt;
         left_q   <= left_d;
         right_q  <= right_d;
         lo_q     <= lo_d;
         hi_q     <= hi_d;
         lock_q   <= lock_d;
         trk_cnt  <= (state == ST_TRACK && trk_cnt != TCW'(SETTLE)) ?
                     trk_cnt + 1'b1 : '0;
         rx_valid <= lock_q;
         rx_data  <= lock_q ? n_word : '0;
      end
   end
endmodule

// File: rtl/diff_lane_aligner_chk.sv
module diff_lane_aligner_chk #(
   parameter int WORD_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [WORD_W-1:0] n_word,
   input logic              n_ld,
   input logic              n_ce,
   input logic              n_inc,
   input logic              p_ld,
   input logic              p_ce,
   input logic              p_inc,
   input logic [WORD_W-1:0] rx_data,
   input logic              rx_valid
);
   // R10
   n_ld_ce_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(n_ld && n_ce));
   // R10
   p_ld_ce_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(p_ld && p_ce));
   // R10
   trk_unison_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> (n_ce == p_ce) && (n_inc == p_inc));
   // R7
   valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> rx_valid);
   // R7
   no_load_trk_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> !n_ld && !p_ld);
   // R8
   data_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> rx_data == $past(n_word));
   // R8
   data_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !rx_valid |-> rx_data == '0);
endmodule

bind diff_lane_aligner diff_lane_aligner_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .n_word   (n_word),
   .n_ld     (n_ld),
   .n_ce     (n_ce),
   .n_inc    (n_inc),
   .p_ld     (p_ld),
   .p_ce     (p_ce),
   .p_inc    (p_inc),
   .rx_data  (rx_data),
   .rx_valid (rx_valid)
);

// File: tb/diff_lane_aligner_test.sv
`timescale 1ns/1ps
module diff_lane_aligner_test;
   localparam int         TW  = 5;
   localparam int         SET = 4;
   localparam int         WN  = 8;
   localparam logic [7:0] PAT = 8'h5A;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst;
   logic [7:0]    n_word, p_word, rx_data;
   logic          n_ld, n_ce, n_inc, p_ld, p_ce, p_inc, rx_valid;
   logic [TW-1:0] n_val, p_val;

   diff_lane_aligner #(
      .TAP_W(TW), .SETTLE(SET), .WIN(WN), .WORD_W(8), .TRAIN_PAT(PAT)
   ) uut (
      .clk(clk), .rst(rst), .n_word(n_word), .p_word(p_word),
      .n_ld(n_ld), .n_ce(n_ce), .n_inc(n_inc), .n_val(n_val),
      .p_ld(p_ld), .p_ce(p_ce), .p_inc(p_inc), .p_val(p_val),
      .rx_data(rx_data), .rx_valid(rx_valid)
   );

   int checks = 0;
   int errors = 0;

   // eye model: N clean in [nl,nr], P noisy in [pl,ph], edge target edge_t
   int nl = 10, nr = 24, pl = 6, ph = 9, edge_t = 7;
   int bn_tap = 0, bp_tap = 0;
   int cnt_nld = 0, cnt_pld = 0;
   int first_n = -1, first_p = -1, last_n = -1, last_p = -1;
   logic [31:0] cyc = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [7:0]  nw_q = 8'h00;
   logic [7:0]  noise;
   logic        early_m;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural delay lines and lane word generation
   always @(posedge clk) begin
      cyc  <= cyc + 1;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      nw_q <= n_word;
      if (n_ld) bn_tap <= int'(n_val);
      else if (n_ce) bn_tap <= n_inc ? bn_tap + 1 : bn_tap - 1;
      if (p_ld) bp_tap <= int'(p_val);
      else if (p_ce) bp_tap <= p_inc ? bp_tap + 1 : bp_tap - 1;
      if (rst) begin
         cnt_nld <= 0;  cnt_pld <= 0;
         first_n <= -1; first_p <= -1;
      end else begin
         if (n_ld) begin
            cnt_nld <= cnt_nld + 1;
            last_n  <= int'(n_val);
            if (cnt_nld == 0) first_n <= int'(n_val);
         end
         if (p_ld) begin
            cnt_pld <= cnt_pld + 1;
            last_p  <= int'(p_val);
            if (cnt_pld == 0) first_p <= int'(p_val);
         end
      end
   end

   always_comb begin
      noise   = PAT ^ (8'h01 << cyc[2:0]);
      early_m = (bp_tap < edge_t) ? 1'b1 : (bp_tap > edge_t) ? 1'b0 : cyc[0];
      if (rx_valid) begin
         n_word = lfsr[7:0];
         for (int i = 0; i < 7; i++)
            p_word[i] = early_m ? n_word[i] : n_word[i+1];
         p_word[7] = n_word[7];
      end else begin
         n_word = (bn_tap >= nl && bn_tap <= nr) ? PAT : noise;
         p_word = (bp_tap >= pl && bp_tap <= ph) ? noise : PAT;
      end
   end

   // per-clock comparison against the bench's own expectations
   always @(negedge clk) begin
      if (!rst) begin
         chk(rx_valid == (cnt_pld >= 2), "R7", "valid vs park load",
             int'(rx_valid), int'(cnt_pld >= 2));
         chk(rx_data == (rx_valid ? nw_q : 8'h00), "R8", "forwarded data",
             int'(rx_data), int'(rx_valid ? nw_q : 8'h00));
         chk(!(n_ld && n_ce) && !(p_ld && p_ce), "R10", "ld with ce",
             int'({n_ld, n_ce, p_ld, p_ce}), 0);
         chk(bn_tap >= 0 && bn_tap < 32 && bp_tap >= 0 && bp_tap < 32,
             "R10", "tap range", bn_tap * 100 + bp_tap, 0);
         if (rx_valid)
            chk(n_ce == p_ce && n_inc == p_inc, "R10", "lanes in unison",
                int'({n_ce, n_inc}), int'({p_ce, p_inc}));
      end
   end

   task automatic calibrate(input int a, input int b, input int c, input int d,
                            input int exp_n, input int exp_p, input string tag);
      nl = a; nr = b; pl = c; ph = d; edge_t = exp_p;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(rx_valid == 1'b0 && rx_data == 8'h00, "R1", {tag, " reset outputs"},
          int'(rx_valid), 0);
      rst = 1'b0;
      for (int t = 0; t < 5000 && !rx_valid; t++) @(negedge clk);
      chk(rx_valid, "R7", {tag, " lock reached"}, int'(rx_valid), 1);
      chk(first_n == 16 && first_p == 16, "R1", {tag, " start loads"},
          first_n * 100 + first_p, 1616);
      chk(last_n == exp_n, "R2 R3 R4 R5", {tag, " N centre"}, last_n, exp_n);
      chk(last_p == exp_p, "R6", {tag, " P edge"}, last_p, exp_p);
      chk(bn_tap == exp_n && bp_tap == exp_p, "R5 R6", {tag, " taps applied"},
          bn_tap * 100 + bp_tap, exp_n * 100 + exp_p);
   endtask

   task automatic track_to(input int tgt, input int gap, input string tag);
      edge_t = tgt;
      repeat (200) @(negedge clk);
      chk(bp_tap >= tgt - 1 && bp_tap <= tgt + 1, "R9", {tag, " P follows edge"},
          bp_tap, tgt);
      chk(bn_tap - bp_tap == gap, "R9", {tag, " spacing kept"},
          bn_tap - bp_tap, gap);
      chk(rx_valid, "R7", {tag, " valid held"}, int'(rx_valid), 1);
   endtask

   initial begin
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(rx_valid == 1'b0 && rx_data == 8'h00, "R1", "power-up state",
          int'(rx_valid), 0);

      // eye centred near start: N window 10..24, P noise 6..9
      calibrate(10, 24, 6, 9, 17, 7, "eye A");
      track_to(7, 10, "hold");
      track_to(10, 10, "drift up");
      track_to(4, 10, "drift down");

      // asynchronous reset between clock edges
      @(negedge clk);
      #2 rst = 1'b1;
      #1 chk(rx_valid == 1'b0 && rx_data == 8'h00, "R1", "async clear",
             int'(rx_valid), 0);

      // start tap noisy on N: both lanes climb to 20
      calibrate(20, 28, 2, 5, 24, 3, "eye B");
      // clean window spans all taps, noise reaches tap 0
      calibrate(0, 31, 0, 3, 15, 1, "eye C");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule